// File: doc/BRIEF.md
# UART Receive Buffer With Status

This block is the receive half of an asynchronous serial port. It watches a serial line that idles high. It qualifies a falling edge as a start bit and recovers eight or nine data bits from a 16x oversample tick. Each finished byte goes into a small queue together with its status. The status is a framing-error bit, an overrun bit and an optional ninth data bit. Because the status rides with the byte, a reader that looks at the status outputs before popping always sees the status of the byte on the data outputs.

Normally the queue holds two entries, so a second byte can arrive while software is still servicing the first. A compatibility control shrinks it to a single entry, so that overrun behaves as it does on a single-register receiver. Software reads the head entry through plain output ports and removes it with a one-cycle pop strobe. A receive-complete output stays high as long as anything is queued.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset the queue is empty: rx_done_o is 0, and rd_data_o, rd_bit8_o, rd_ferr_o and rd_ovr_o are all 0 (the ninth data bit resets to 0).
- R2: A falling edge on rx_i starts a frame only while rx_en_i is 1. A complete frame sent while rx_en_i is 0 leaves no entry.
- R3: The start bit is confirmed by a majority vote of the synchronised line on oversample ticks 7, 8 and 9 of the bit, counted from 0. A low pulse that fails the vote stores nothing, and the receiver waits for the next falling edge.
- R4: Data bits arrive LSB first and each is the majority of ticks 7, 8 and 9 of its bit period. The entry becomes visible one clock after the clock edge on which the tick-9 sample of the stop bit is taken.
- R5: With nine_bit_i at 1 when the start edge is accepted, a ninth data bit follows bit 7 and appears on rd_bit8_o. With nine_bit_i at 0, eight bits are received and rd_bit8_o of that entry is 0.
- R6: A stop bit that votes 0 still stores the byte, with rd_ferr_o at 1. A stop bit that votes 1 gives rd_ferr_o at 0.
- R7: With compat_i at 0 the queue holds two entries. The outputs show the oldest entry, with its own status bits. A pulse on rd_pop_i removes the oldest entry.
- R8: With compat_i at 1 the queue holds one entry.
- R9: A frame that completes while the queue is full is discarded. The next entry that is stored carries rd_ovr_o at 1, and every other entry carries 0.
- R10: A pop and a frame completion on the same clock edge with the queue full are both performed, and no overrun is recorded.
- R11: A pop while the queue is empty has no effect on later contents or outputs.
- R12: rx_done_o is 1 exactly while the queue is non-empty. While it is empty all data and status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| rx_en_i | input | 1 | Receive enable; gates start-edge acceptance |
| nine_bit_i | input | 1 | Selects nine data bits per frame |
| compat_i | input | 1 | Limits the queue to one entry |
| os_tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| rd_pop_i | input | 1 | Removes the head entry |
| rd_data_o | output | 8 | Head entry data byte |
| rd_bit8_o | output | 1 | Head entry ninth data bit |
| rd_ferr_o | output | 1 | Head entry framing error |
| rd_ovr_o | output | 1 | Head entry overrun mark |
| rx_done_o | output | 1 | Queue non-empty |

## Verification
The bench keeps a queue-based model of the buffer and predicts the clock on which each frame lands. The corner cases are a third byte arriving while two are held, a pop that lands on that same edge, a second byte in single-entry mode, a pop on an empty queue and a start glitch too short to pass the vote. A design that keeps status in a separate register would show the framing error of the wrong byte after one pop. One that marks overrun on the byte already queued, or that fails to clear the mark, would show rd_ovr_o on the wrong entry. Ignoring the compatibility control would accept a second byte. A pop on an empty queue that moves the pointers anyway would cause later reads to return stale entries.

// File: rtl/rxb_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial receive buffer: one queue entry and the
// frame receiver state encoding.
package rxb_pkg;

    // Width of the data byte carried by each queue entry.
    localparam int RXB_DW = 8;

    // One stored byte with the status that belongs to it.
    typedef struct packed {
        logic              ovr;
        logic              ferr;
        logic              bit8;
        logic [RXB_DW-1:0] data;
    } rxb_entry_t;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rxb_state_e;

endpackage

// File: rtl/rxb_sync.sv
`timescale 1ns/1ps
// Line synchroniser and falling-edge detector.
// Brings the asynchronous serial line into the clock domain through STAGES
// flops and flags a high-to-low transition of the synchronised value.
// Assumes STAGES >= 2 and that the line idles high (reset value is 1).
module rxb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o,
    output logic fall_o
);

    logic [STAGES-1:0] sr_q;
    logic              prev_q;

    // Shift the raw line through the synchroniser and keep the last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '1;
            prev_q <= 1'b1;
        end else begin
            sr_q   <= {sr_q[STAGES-2:0], line_i};
            prev_q <= sr_q[STAGES-1];
        end
    end

    assign line_o = sr_q[STAGES-1];
    assign fall_o = prev_q & ~sr_q[STAGES-1];

endmodule

// File: rtl/rxb_frame.sv
`timescale 1ns/1ps
// Frame receiver.
// Accepts a falling edge as a start candidate while enabled, confirms it by
// a three-sample majority around mid-bit, then collects 8 or 9 data bits LSB
// first and judges the stop bit. Issues a one-cycle done pulse with the
// finished entry (ovr always 0 here) at mid stop bit, then returns to idle
// so the next start edge can be caught during the rest of the stop bit.
// Assumes tick_i pulses for one clock at OS_RATE times the bit rate and
// OS_RATE >= 4.
module rxb_frame
    import rxb_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    input  logic       fall_i,
    input  logic       en_i,
    input  logic       nine_i,
    input  logic       tick_i,
    output logic       done_o,
    output rxb_entry_t entry_o
);

    localparam int CW  = $clog2(OS_RATE);
    localparam int MID = OS_RATE / 2;
    localparam int BW  = $clog2(RXB_DW + 1);
    localparam logic [CW-1:0] S_FIRST = CW'(MID - 1);
    localparam logic [CW-1:0] S_SECND = CW'(MID);
    localparam logic [CW-1:0] S_VOTE  = CW'(MID + 1);
    localparam logic [CW-1:0] C_END   = CW'(OS_RATE - 1);

    rxb_state_e      state_q;
    logic [CW-1:0]   cnt_q;
    logic [BW-1:0]   bit_q;
    logic [1:0]      samp_q;
    logic [RXB_DW:0] shreg_q;
    logic            nine_q;
    logic            done_q;
    rxb_entry_t      out_q;
    logic            vote;
    logic [BW-1:0]   last_bit;

    // Majority of the two held samples and the current one.
    always_comb begin
        vote = (samp_q[1] & samp_q[0]) | (samp_q[1] & line_i) | (samp_q[0] & line_i);
    end

    // Index of the final data bit for the width latched at the start edge.
    always_comb begin
        last_bit = nine_q ? BW'(RXB_DW) : BW'(RXB_DW - 1);
    end

    // Frame sequencing, bit sampling and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            samp_q  <= 2'b11;
            shreg_q <= '0;
            nine_q  <= 1'b0;
            done_q  <= 1'b0;
            out_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (state_q == RX_IDLE) begin
                if (fall_i && en_i) begin
                    state_q <= RX_START;
                    cnt_q   <= '0;
                    bit_q   <= '0;
                    shreg_q <= '0;
                    nine_q  <= nine_i;
                end
            end else if (tick_i) begin
                cnt_q <= (cnt_q == C_END) ? '0 : cnt_q + CW'(1);
                if (cnt_q == S_FIRST || cnt_q == S_SECND) begin
                    samp_q <= {samp_q[0], line_i};
                end
                if (cnt_q == S_VOTE) begin
                    if (state_q == RX_START) begin
                        if (vote) begin
                            state_q <= RX_IDLE;
                        end
                    end else if (state_q == RX_DATA) begin
                        shreg_q[bit_q] <= vote;
                    end else begin
                        done_q        <= 1'b1;
                        out_q.data    <= shreg_q[RXB_DW-1:0];
                        out_q.bit8    <= nine_q & shreg_q[RXB_DW];
                        out_q.ferr    <= ~vote;
                        out_q.ovr     <= 1'b0;
                        state_q       <= RX_IDLE;
                    end
                end
                if (cnt_q == C_END) begin
                    if (state_q == RX_START) begin
                        state_q <= RX_DATA;
                        bit_q   <= '0;
                    end else if (state_q == RX_DATA) begin
                        if (bit_q == last_bit) begin
                            state_q <= RX_STOP;
                        end else begin
                            bit_q <= bit_q + BW'(1);
                        end
                    end
                end
            end
        end
    end

    assign done_o  = done_q;
    assign entry_o = out_q;

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_IDLE && !en_i) |=> (state_q == RX_IDLE));

    // R3
    false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_START && tick_i && cnt_q == S_VOTE && vote) |=> (state_q == RX_IDLE && !done_o));

    // R6
    stop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_STOP && tick_i && cnt_q == S_VOTE) |=> (done_o && entry_o.ferr == !$past(vote)));

endmodule

// File: rtl/rxb_fifo.sv
`timescale 1ns/1ps
// Receive queue of DEPTH entries with a run-time capacity limit.
// compat_i caps occupancy at one entry. A push that finds no room is dropped
// and arms an overrun mark that is written into the next accepted entry.
// A pop on an empty queue does nothing. Pop and push on one edge are both
// honoured, the pop freeing room first. Assumes DEPTH >= 2 and that compat_i
// only changes while the queue is empty.
module rxb_fifo
    import rxb_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_i,
    input  rxb_entry_t entry_i,
    input  logic       pop_i,
    input  logic       compat_i,
    output rxb_entry_t head_o,
    output logic       nonempty_o
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] P_LAST = PW'(DEPTH - 1);

    logic [PW-1:0] wptr_q;
    logic [PW-1:0] rptr_q;
    logic [CW-1:0] count_q;
    logic          ovr_pend_q;
    logic [CW-1:0] cap;
    logic [CW-1:0] after_pop;
    logic          pop_eff;
    logic          room;
    logic          wr_en;
    rxb_entry_t    wr_entry;
    rxb_entry_t    slot_w [DEPTH];

    // Capacity, effective pop and admission of the incoming entry.
    always_comb begin
        cap       = compat_i ? CW'(1) : CW'(DEPTH);
        pop_eff   = pop_i && (count_q != '0);
        after_pop = count_q - CW'(pop_eff);
        room      = after_pop < cap;
        wr_en     = push_i && room;
        wr_entry      = entry_i;
        wr_entry.ovr  = ovr_pend_q;
    end

    // One storage register per slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        rxb_entry_t slot_q;

        // Load this slot when the write pointer selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_en && wptr_q == PW'(g)) begin
                slot_q <= wr_entry;
            end
        end

        assign slot_w[g] = slot_q;
    end

    // Pointer, occupancy and overrun-mark bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q     <= '0;
            rptr_q     <= '0;
            count_q    <= '0;
            ovr_pend_q <= 1'b0;
        end else begin
            if (wr_en) begin
                wptr_q <= (wptr_q == P_LAST) ? '0 : wptr_q + PW'(1);
            end
            if (pop_eff) begin
                rptr_q <= (rptr_q == P_LAST) ? '0 : rptr_q + PW'(1);
            end
            count_q <= after_pop + CW'(wr_en);
            if (push_i && !room) begin
                ovr_pend_q <= 1'b1;
            end else if (wr_en) begin
                ovr_pend_q <= 1'b0;
            end
        end
    end

    assign nonempty_o = (count_q != '0);
    assign head_o     = nonempty_o ? slot_w[rptr_q] : '0;

    // R7
    fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !pop_eff) |=> (count_q == $past(count_q) + CW'(1)));

    // R8
    compat_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (compat_i && nonempty_o && push_i && !pop_i) |=> (count_q == $past(count_q)));

    // R9
    ovr_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ovr_pend_q && !nonempty_o) |=> head_o.ovr);

    // R11
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nonempty_o && pop_i && !push_i) |=> (!nonempty_o && head_o == '0));

endmodule

// File: rtl/uart_rx_buffer.sv
`timescale 1ns/1ps
// Serial receive path with a status-carrying receive queue.
// Synchronises the line, receives frames against an oversample tick and
// queues each byte with its framing, overrun and ninth-bit status. The head
// entry is presented on the read ports and removed by rd_pop_i.
// Assumes os_tick_i is a single-cycle pulse at OS_RATE times the bit rate.
module uart_rx_buffer
    import rxb_pkg::*;
#(
    parameter int OS_RATE     = 16,
    parameter int DEPTH       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic              rx_en_i,
    input  logic              nine_bit_i,
    input  logic              compat_i,
    input  logic              os_tick_i,
    input  logic              rd_pop_i,
    output logic [RXB_DW-1:0] rd_data_o,
    output logic              rd_bit8_o,
    output logic              rd_ferr_o,
    output logic              rd_ovr_o,
    output logic              rx_done_o
);

    logic       line_s;
    logic       line_fall;
    logic       frame_done;
    rxb_entry_t frame_entry;
    rxb_entry_t head;

    rxb_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (rx_i),
        .line_o (line_s),
        .fall_o (line_fall)
    );

    rxb_frame #(
        .OS_RATE (OS_RATE)
    ) frame_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (line_s),
        .fall_i  (line_fall),
        .en_i    (rx_en_i),
        .nine_i  (nine_bit_i),
        .tick_i  (os_tick_i),
        .done_o  (frame_done),
        .entry_o (frame_entry)
    );

    rxb_fifo #(
        .DEPTH (DEPTH)
    ) fifo_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (frame_done),
        .entry_i    (frame_entry),
        .pop_i      (rd_pop_i),
        .compat_i   (compat_i),
        .head_o     (head),
        .nonempty_o (rx_done_o)
    );

    assign rd_data_o = head.data;
    assign rd_bit8_o = head.bit8;
    assign rd_ferr_o = head.ferr;
    assign rd_ovr_o  = head.ovr;

    // R12
    empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done_o |-> (rd_data_o == '0 && !rd_bit8_o && !rd_ferr_o && !rd_ovr_o));

endmodule

// File: tb/uart_rx_buffer_tb_top.sv
`timescale 1ns/1ps
module uart_rx_buffer_tb_top;

    localparam int OS     = 16;
    localparam int DIV    = 4;
    localparam int BITCYC = OS * DIV;

    logic       clk    = 1'b0;
    logic       rst_n  = 1'b0;
    logic       rx     = 1'b1;
    logic       rx_en  = 1'b1;
    logic       nine   = 1'b0;
    logic       compat = 1'b0;
    logic       tick   = 1'b0;
    logic       rd     = 1'b0;
    logic [7:0] rd_data;
    logic       rd_bit8;
    logic       rd_ferr;
    logic       rd_ovr;
    logic       rx_done;

    int  checks   = 0;
    int  fails    = 0;
    bit  finished = 1'b0;
    int  cyc      = 0;
    int  tdiv     = 0;

    logic [10:0] mq[$];
    int          pend_cyc[$];
    logic [9:0]  pend_val[$];
    logic        m_ovr = 1'b0;

    always #4 clk = ~clk;

    uart_rx_buffer #(
        .OS_RATE     (OS),
        .DEPTH       (2),
        .SYNC_STAGES (2)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_i       (rx),
        .rx_en_i    (rx_en),
        .nine_bit_i (nine),
        .compat_i   (compat),
        .os_tick_i  (tick),
        .rd_pop_i   (rd),
        .rd_data_o  (rd_data),
        .rd_bit8_o  (rd_bit8),
        .rd_ferr_o  (rd_ferr),
        .rd_ovr_o   (rd_ovr),
        .rx_done_o  (rx_done)
    );

    // Oversample tick: one clock in every DIV.
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % DIV;
        tick = (tdiv == 0);
    end

    // Reference model: behavioural queue updated on each clock edge.
    always @(posedge clk) begin
        logic [9:0] v;
        int         cap;
        if (!rst_n) begin
            mq.delete();
            m_ovr = 1'b0;
        end else begin
            if (rd && mq.size() > 0) void'(mq.pop_front());
            if (pend_cyc.size() > 0 && pend_cyc[0] == cyc) begin
                void'(pend_cyc.pop_front());
                v   = pend_val.pop_front();
                cap = compat ? 1 : 2;
                if (mq.size() < cap) begin
                    mq.push_back({m_ovr, v});
                    m_ovr = 1'b0;
                end else begin
                    m_ovr = 1'b1;
                end
            end
        end
        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Every-clock comparison against the model.
    always @(negedge clk) begin
        logic [10:0] eh;
        logic [10:0] ah;
        if (rst_n && !finished) begin
            eh = (mq.size() > 0) ? mq[0] : 11'h0;
            ah = {rd_ovr, rd_ferr, rd_bit8, rd_data};
            chk(rx_done == (mq.size() > 0), "R12 rx_done vs queue occupancy", 32'(rx_done), 32'(mq.size() > 0));
            chk(ah == eh, "R7 head entry {ovr,ferr,bit8,data}", 32'(ah), 32'(eh));
        end
    end

    task automatic align_tick();
        do @(posedge clk); while (tick !== 1'b1);
    endtask

    task automatic send_frame(input logic [8:0] val, input bit stop_ok);
        int t0;
        int nb;
        align_tick();
        t0 = cyc;
        nb = nine ? 9 : 8;
        if (rx_en) begin
            pend_cyc.push_back(t0 + 1 + DIV * (1 + OS * (1 + nb) + OS / 2 + 1));
            pend_val.push_back({~stop_ok, nine & val[8], val[7:0]});
        end
        @(negedge clk);
        rx = 1'b0;
        repeat (BITCYC) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rx = val[i];
            repeat (BITCYC) @(negedge clk);
        end
        rx = stop_ok;
        repeat (BITCYC) @(negedge clk);
        rx = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic glitch();
        align_tick();
        @(negedge clk);
        rx = 1'b0;
        repeat (16) @(negedge clk);
        rx = 1'b1;
        repeat (2 * BITCYC) @(negedge clk);
    endtask

    task automatic pop();
        @(negedge clk);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic pop_at(input int tgt);
        do @(negedge clk); while (cyc != tgt);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rx_done == 1'b0, "R1 rx_done after reset", 32'(rx_done), 0);
        chk({rd_ovr, rd_ferr, rd_bit8, rd_data} == 11'h0, "R1 outputs after reset",
            32'({rd_ovr, rd_ferr, rd_bit8, rd_data}), 0);
        chk(rd_bit8 == 1'b0, "R1 ninth bit reset value", 32'(rd_bit8), 0);

        // R4 plain 8-bit frame
        send_frame(9'h0A5, 1'b1);
        chk(rx_done == 1'b1, "R4 byte stored", 32'(rx_done), 1);
        chk(rd_data == 8'hA5, "R4 data LSB first", 32'(rd_data), 32'hA5);
        pop();
        chk(rx_done == 1'b0 && rd_data == 8'h0, "R12 empty after pop", 32'(rd_data), 0);

        // R2 frame while disabled
        rx_en = 1'b0;
        send_frame(9'h03C, 1'b1);
        chk(rx_done == 1'b0, "R2 disabled frame ignored", 32'(rx_done), 0);
        rx_en = 1'b1;

        // R3 short start glitch
        glitch();
        chk(rx_done == 1'b0, "R3 glitch rejected", 32'(rx_done), 0);
        send_frame(9'h05A, 1'b1);
        chk(rd_data == 8'h5A, "R3 recovery after glitch", 32'(rd_data), 32'h5A);
        pop();

        // R5 nine-bit frames
        nine = 1'b1;
        send_frame(9'h1C3, 1'b1);
        chk(rd_data == 8'hC3 && rd_bit8 == 1'b1, "R5 ninth bit set", 32'({rd_bit8, rd_data}), 32'h1C3);
        pop();
        send_frame(9'h0F0, 1'b1);
        chk(rd_data == 8'hF0 && rd_bit8 == 1'b0, "R5 ninth bit clear", 32'({rd_bit8, rd_data}), 32'h0F0);
        pop();
        nine = 1'b0;
        send_frame(9'h181, 1'b1);
        chk(rd_data == 8'h81 && rd_bit8 == 1'b0, "R5 eight-bit mode", 32'({rd_bit8, rd_data}), 32'h081);
        pop();

        // R6 and R7 status travels with each byte
        send_frame(9'h011, 1'b0);
        send_frame(9'h022, 1'b1);
        chk(rd_data == 8'h11 && rd_ferr == 1'b1, "R6 framing error on first", 32'({rd_ferr, rd_data}), 32'h111);
        pop();
        chk(rd_data == 8'h22 && rd_ferr == 1'b0, "R7 second entry own status", 32'({rd_ferr, rd_data}), 32'h022);
        pop();

        // R9 overrun
        send_frame(9'h031, 1'b1);
        send_frame(9'h032, 1'b1);
        send_frame(9'h033, 1'b1);
        chk(rd_data == 8'h31 && rd_ovr == 1'b0, "R9 first entry unmarked", 32'({rd_ovr, rd_data}), 32'h031);
        pop();
        chk(rd_data == 8'h32 && rd_ovr == 1'b0, "R9 second entry unmarked", 32'({rd_ovr, rd_data}), 32'h032);
        pop();
        chk(rx_done == 1'b0, "R9 third byte discarded", 32'(rx_done), 0);
        send_frame(9'h034, 1'b1);
        chk(rd_data == 8'h34 && rd_ovr == 1'b1, "R9 next entry marked", 32'({rd_ovr, rd_data}), 32'h134);
        pop();
        send_frame(9'h035, 1'b1);
        chk(rd_ovr == 1'b0, "R9 mark cleared", 32'(rd_ovr), 0);
        pop();

        // R8 single-entry mode
        compat = 1'b1;
        send_frame(9'h041, 1'b1);
        send_frame(9'h042, 1'b1);
        chk(rd_data == 8'h41, "R8 head is first", 32'(rd_data), 32'h41);
        pop();
        chk(rx_done == 1'b0, "R8 second byte dropped", 32'(rx_done), 0);
        send_frame(9'h043, 1'b1);
        chk(rd_data == 8'h43 && rd_ovr == 1'b1, "R8 overrun in single mode", 32'({rd_ovr, rd_data}), 32'h143);
        pop();
        compat = 1'b0;

        // R10 pop and completion on the same edge while full
        send_frame(9'h051, 1'b1);
        send_frame(9'h052, 1'b1);
        fork
            send_frame(9'h053, 1'b1);
            begin
                wait (pend_cyc.size() > 0);
                pop_at(pend_cyc[0]);
            end
        join
        chk(rd_data == 8'h52 && rd_ovr == 1'b0, "R10 head after same-edge pop", 32'({rd_ovr, rd_data}), 32'h052);
        pop();
        chk(rd_data == 8'h53 && rd_ovr == 1'b0, "R10 third byte kept", 32'({rd_ovr, rd_data}), 32'h053);
        pop();

        // R11 pop on empty queue
        pop();
        chk(rx_done == 1'b0 && rd_data == 8'h0, "R11 empty pop harmless", 32'(rx_done), 0);
        send_frame(9'h066, 1'b1);
        chk(rd_data == 8'h66 && rd_ovr == 1'b0 && rd_ferr == 1'b0, "R11 later byte intact",
            32'({rd_ovr, rd_ferr, rd_data}), 32'h066);
        pop();
        chk(rx_done == 1'b0, "R12 drained", 32'(rx_done), 0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule